// File: doc/BRIEF.md
# Backplane PCM Port with Signaling Insertion

This block is the line-card facing frame port of a master loop transceiver. Toward the backplane it behaves like a codec's serial interface. Each frame it shifts in one PCM word under a receive enable and shifts out one PCM word under a transmit enable, both timed by an external data clock. On each frame sync rising edge it hands the received word and the two signaling input bits to the modulator side. On the same edge it publishes the signaling bits and the valid flag of the last demodulated frame.

An insert mode carries signaling channel 2 through the voice path. In that mode the outgoing PCM word carries received signaling bit 2 in its LSB. Signaling bit 2 toward the far end is taken from the LSB of the incoming PCM word, and that LSB is cleared in the word sent on.

A bus-sharing enable lets several ports share control and status wiring. While it is low, the port freezes its control inputs and turns off its status output enable.

All pin inputs are asynchronous. They are resynchronized to a system clock that runs at least eight times faster than the data clock, and every edge is detected on the synchronized samples.

Top module: `pcm_sig_port`

## Requirements
- R1: After a rising edge of `rx_en_i`, the next eight falling edges of `dclk_i` each capture one `rx_dat_i` bit, MSB first. With insert mode off, that word appears on `mod_voice_o` after the next frame sync rising edge.
- R2: While `tx_en_i` is high, the first eight rising edges of `dclk_i` (counting one coincident with the enable's rise) each present one bit of the transmit word on `tx_dat_o`, MSB first. `tx_oe_o` is high only while the enable is high.
- R3: The transmit word is reloaded at a frame sync rising edge that falls outside an enable window. A frame sync inside the window defers the reload to the ninth rising data clock edge of that window, and the word being shifted out is not disturbed.
- R4: On a frame sync rising edge, `mod_sig_o[0]` takes the latched signaling input 1 and `mod_sig_o[1]` takes the latched signaling input 2. On the same edge, `so1_o`, `so2_o` and `vd_o` take signaling bit 0, signaling bit 1 and the valid flag of the buffered demodulated frame.
- R5: With insert mode latched on at a frame sync, three things change. The transmit word is the demodulated voice word with bit 0 replaced by demodulated signaling bit 1. `mod_sig_o[1]` is the received word's bit 0. `mod_voice_o` is the received word with bit 0 forced to 0.
- R6: While `sig_en_i` is low, the latched insert mode, power-down, loopback and signaling inputs hold their last values whatever those pins do, and `stat_oe_o` is low.
- R7: A demodulated frame is captured on `dem_stb_i` and held until the next frame sync. If no strobe arrives between two frame syncs, `vd_o` is 0 after the second one.
- R8: After reset every output is 0, including `tx_oe_o` and `stat_oe_o`.
- R9: While `sig_en_i` is high, `pd_q_o` and `lb_q_o` follow the synchronized power-down and loopback pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dclk_i | input | 1 | External data clock |
| fsync_i | input | 1 | Frame sync |
| rx_en_i | input | 1 | Receive word enable |
| rx_dat_i | input | 1 | Serial PCM data from backplane |
| tx_en_i | input | 1 | Transmit word enable |
| tx_dat_o | output | 1 | Serial PCM data to backplane |
| tx_oe_o | output | 1 | Drive enable for tx_dat_o |
| sig_en_i | input | 1 | Bus-sharing enable |
| ins_en_i | input | 1 | Signaling insertion mode |
| pd_i | input | 1 | Power-down control |
| lb_i | input | 1 | Loopback control |
| si1_i | input | 1 | Signaling input 1 |
| si2_i | input | 1 | Signaling input 2 |
| dem_stb_i | input | 1 | Demodulated frame strobe |
| dem_voice_i | input | WORD_W | Demodulated voice word |
| dem_sig_i | input | 2 | Demodulated signaling bits |
| dem_vld_i | input | 1 | Demodulated frame valid |
| mod_voice_o | output | WORD_W | Voice word toward modulator |
| mod_sig_o | output | 2 | Signaling bits toward modulator |
| so1_o | output | 1 | Received signaling bit 1 |
| so2_o | output | 1 | Received signaling bit 2 |
| vd_o | output | 1 | Received frame valid |
| stat_oe_o | output | 1 | Drive enable for so1_o, so2_o, vd_o |
| pd_q_o | output | 1 | Latched power-down |
| lb_q_o | output | 1 | Latched loopback |

## Verification
The bench builds the block with its defaults: an 8-bit word and a two-stage synchronizer. It drives a data clock of 16 system clocks per period, which leaves only a few cycles of margin between the synchronizer delay and each data clock half period. At that ratio a frame sync placed between the fourth and fifth transmit bits can land inside the window and expose the deferred reload. The 8-bit word width lets the MSB-first order and the LSB substitution be checked against bench-computed words.

// File: rtl/pcm_sig_pkg.sv
package pcm_sig_pkg;
  // positions of the asynchronous pins inside the synchronizer bundle
  localparam int IX_DCK  = 0;
  localparam int IX_FS   = 1;
  localparam int IX_RXEN = 2;
  localparam int IX_RXD  = 3;
  localparam int IX_TXEN = 4;
  localparam int IX_SEN  = 5;
  localparam int IX_INS  = 6;
  localparam int IX_PD   = 7;
  localparam int IX_LB   = 8;
  localparam int IX_SI1  = 9;
  localparam int IX_SI2  = 10;
  localparam int NUM_SYNC = 11;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[g] <= '0;
      else if (g == 0) st[g] <= d_i;
      else st[g] <= st[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         fall_i,
  input  logic         din_i,
  output logic [W-1:0] word_o
);
  localparam int CW = $clog2(W+1);

  logic [CW-1:0] cnt, cnt_eff;
  logic [W-1:0]  sh, nxt;

  always_comb begin
    cnt_eff = start_i ? CW'(W) : cnt;
    nxt     = {sh[W-2:0], din_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sh     <= '0;
      word_o <= '0;
    end else begin
      cnt <= cnt_eff;
      if (fall_i && cnt_eff != '0) begin
        sh  <= nxt;
        cnt <= cnt_eff - 1'b1;
        if (cnt_eff == CW'(1)) word_o <= nxt;
      end
    end
  end
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         win_i,
  input  logic         rise_i,
  input  logic         fs_i,
  input  logic [W-1:0] word_i,
  output logic         dat_o,
  output logic         oe_o
);
  localparam int CW = $clog2(W+2);

  logic [CW-1:0] cnt, cnt_eff;
  logic [W-1:0]  treg, nxt, sh;
  logic          pend;

  always_comb cnt_eff = start_i ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      treg  <= '0;
      nxt   <= '0;
      sh    <= '0;
      pend  <= 1'b0;
      dat_o <= 1'b0;
      oe_o  <= 1'b0;
    end else begin
      oe_o <= win_i;
      cnt  <= cnt_eff;
      if (rise_i && win_i) begin
        if (cnt_eff == '0) begin
          dat_o <= treg[W-1];
          sh    <= {treg[W-2:0], 1'b0};
          cnt   <= cnt_eff + 1'b1;
        end else if (cnt_eff < CW'(W)) begin
          dat_o <= sh[W-1];
          sh    <= {sh[W-2:0], 1'b0};
          cnt   <= cnt_eff + 1'b1;
        end else if (cnt_eff == CW'(W)) begin
          cnt <= cnt_eff + 1'b1;
          if (pend) begin
            treg <= nxt;
            pend <= 1'b0;
          end
        end
      end
      if (fs_i) begin
        if (win_i && cnt_eff <= CW'(W)) begin
          nxt  <= word_i;
          pend <= 1'b1;
        end else begin
          treg <= word_i;
          pend <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_sig_port.sv
module pcm_sig_port
  import pcm_sig_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dclk_i,
  input  logic              fsync_i,
  input  logic              rx_en_i,
  input  logic              rx_dat_i,
  input  logic              tx_en_i,
  output logic              tx_dat_o,
  output logic              tx_oe_o,
  input  logic              sig_en_i,
  input  logic              ins_en_i,
  input  logic              pd_i,
  input  logic              lb_i,
  input  logic              si1_i,
  input  logic              si2_i,
  input  logic              dem_stb_i,
  input  logic [WORD_W-1:0] dem_voice_i,
  input  logic [1:0]        dem_sig_i,
  input  logic              dem_vld_i,
  output logic [WORD_W-1:0] mod_voice_o,
  output logic [1:0]        mod_sig_o,
  output logic              so1_o,
  output logic              so2_o,
  output logic              vd_o,
  output logic              stat_oe_o,
  output logic              pd_q_o,
  output logic              lb_q_o
);
  logic [NUM_SYNC-1:0] raw, s;
  logic [3:0]          lv, prev;
  logic                dck_rise, dck_fall, fs_rise, rx_start, tx_start;
  logic                sen_s, ins_q, si1_q, si2_q;
  logic [WORD_W-1:0]   rx_word, dvoice, tx_next;
  logic [1:0]          dsig;
  logic                dvld;

  always_comb begin
    raw           = '0;
    raw[IX_DCK]   = dclk_i;
    raw[IX_FS]    = fsync_i;
    raw[IX_RXEN]  = rx_en_i;
    raw[IX_RXD]   = rx_dat_i;
    raw[IX_TXEN]  = tx_en_i;
    raw[IX_SEN]   = sig_en_i;
    raw[IX_INS]   = ins_en_i;
    raw[IX_PD]    = pd_i;
    raw[IX_LB]    = lb_i;
    raw[IX_SI1]   = si1_i;
    raw[IX_SI2]   = si2_i;
  end

  pin_sync #(.W(NUM_SYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(s)
  );

  assign lv = {s[IX_TXEN], s[IX_RXEN], s[IX_FS], s[IX_DCK]};

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lv;
  end

  assign dck_rise = lv[0] & ~prev[0];
  assign dck_fall = ~lv[0] & prev[0];
  assign fs_rise  = lv[1] & ~prev[1];
  assign rx_start = lv[2] & ~prev[2];
  assign tx_start = lv[3] & ~prev[3];
  assign sen_s    = s[IX_SEN];

  // control latch for the shared bus
  always_ff @(posedge clk) begin
    if (rst) begin
      ins_q     <= 1'b0;
      si1_q     <= 1'b0;
      si2_q     <= 1'b0;
      pd_q_o    <= 1'b0;
      lb_q_o    <= 1'b0;
      stat_oe_o <= 1'b0;
    end else begin
      stat_oe_o <= sen_s;
      if (sen_s) begin
        ins_q  <= s[IX_INS];
        si1_q  <= s[IX_SI1];
        si2_q  <= s[IX_SI2];
        pd_q_o <= s[IX_PD];
        lb_q_o <= s[IX_LB];
      end
    end
  end

  pcm_rx_shift #(.W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .start_i(rx_start), .fall_i(dck_fall),
    .din_i(s[IX_RXD]), .word_o(rx_word)
  );

  assign tx_next = ins_q ? {dvoice[WORD_W-1:1], dsig[1]} : dvoice;

  pcm_tx_shift #(.W(WORD_W)) u_tx (
    .clk(clk), .rst(rst), .start_i(tx_start), .win_i(lv[3]),
    .rise_i(dck_rise), .fs_i(fs_rise), .word_i(tx_next),
    .dat_o(tx_dat_o), .oe_o(tx_oe_o)
  );

  // demodulated frame buffer and frame-sync publication
  always_ff @(posedge clk) begin
    if (rst) begin
      dvoice      <= '0;
      dsig        <= '0;
      dvld        <= 1'b0;
      mod_voice_o <= '0;
      mod_sig_o   <= '0;
      so1_o       <= 1'b0;
      so2_o       <= 1'b0;
      vd_o        <= 1'b0;
    end else begin
      if (fs_rise) begin
        mod_voice_o <= ins_q ? {rx_word[WORD_W-1:1], 1'b0} : rx_word;
        mod_sig_o   <= {ins_q ? rx_word[0] : si2_q, si1_q};
        so1_o       <= dsig[0];
        so2_o       <= dsig[1];
        vd_o        <= dvld;
        dvld        <= 1'b0;
      end
      if (dem_stb_i) begin
        dvoice <= dem_voice_i;
        dsig   <= dem_sig_i;
        dvld   <= dem_vld_i;
      end
    end
  end
endmodule

// File: rtl/pcm_sig_port_chk.sv
module pcm_sig_port_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              fs_rise,
  input logic              dck_rise,
  input logic              sen_s,
  input logic              ins_q,
  input logic              tx_dat_o,
  input logic [WORD_W-1:0] mod_voice_o,
  input logic              vd_o,
  input logic              pd_q_o,
  input logic              lb_q_o
);
  // R1
  mod_word_fs_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mod_voice_o) |-> $past(fs_rise));
  // R5
  ins_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fs_rise) && $past(ins_q) |-> !mod_voice_o[0]);
  // R2
  tx_bit_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_dat_o) |-> $past(dck_rise));
  // R6
  ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sen_s) |-> $stable(pd_q_o) && $stable(lb_q_o));
  // R4
  vd_fs_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(vd_o) |-> $past(fs_rise));
endmodule

bind pcm_sig_port pcm_sig_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .fs_rise(fs_rise), .dck_rise(dck_rise),
  .sen_s(sen_s), .ins_q(ins_q), .tx_dat_o(tx_dat_o),
  .mod_voice_o(mod_voice_o), .vd_o(vd_o), .pd_q_o(pd_q_o), .lb_q_o(lb_q_o)
);

// File: tb/pcm_sig_port_bench.sv
module pcm_sig_port_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dclk = 0, fsync = 0, rx_en = 0, rx_dat = 0, tx_en = 0;
  logic sen = 0, ins = 0, pd = 0, lb = 0, si1 = 0, si2 = 0;
  logic dem_stb = 0, dem_vld = 0;
  logic [7:0] dem_voice = '0;
  logic [1:0] dem_sig = '0;
  logic tx_dat, tx_oe, so1, so2, vd, stat_oe, pd_q, lb_q;
  logic [7:0] mod_voice;
  logic [1:0] mod_sig;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pcm_sig_port u_pcm_sig_port (
    .clk(clk), .rst(rst), .dclk_i(dclk), .fsync_i(fsync), .rx_en_i(rx_en),
    .rx_dat_i(rx_dat), .tx_en_i(tx_en), .tx_dat_o(tx_dat), .tx_oe_o(tx_oe),
    .sig_en_i(sen), .ins_en_i(ins), .pd_i(pd), .lb_i(lb), .si1_i(si1),
    .si2_i(si2), .dem_stb_i(dem_stb), .dem_voice_i(dem_voice),
    .dem_sig_i(dem_sig), .dem_vld_i(dem_vld), .mod_voice_o(mod_voice),
    .mod_sig_o(mod_sig), .so1_o(so1), .so2_o(so2), .vd_o(vd),
    .stat_oe_o(stat_oe), .pd_q_o(pd_q), .lb_q_o(lb_q)
  );

  function automatic logic [7:0] f_tx(logic [7:0] v, logic s2, logic im);
    return im ? {v[7:1], s2} : v;
  endfunction
  function automatic logic [7:0] f_mv(logic [7:0] rw, logic im);
    return im ? {rw[7:1], 1'b0} : rw;
  endfunction
  function automatic logic [1:0] f_ms(logic a, logic b, logic [7:0] rw, logic im);
    return {im ? rw[0] : b, a};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic rx_word(input logic [7:0] w);
    dclk = 1; rx_en = 1; rx_dat = w[7];
    half();
    for (int i = 0; i < 8; i++) begin
      dclk = 0; half();
      dclk = 1;
      if (i < 7) rx_dat = w[6-i];
      half();
    end
    rx_en = 0; dclk = 0; half();
  endtask

  task automatic fs_pulse();
    fsync = 1; half(); fsync = 0; half();
  endtask

  task automatic strobe(input logic [7:0] v, input logic [1:0] sg, input logic vl);
    @(negedge clk);
    dem_voice = v; dem_sig = sg; dem_vld = vl; dem_stb = 1;
    @(negedge clk);
    dem_stb = 0;
  endtask

  task automatic tx_window(input bit mid_fs, output logic [7:0] bits);
    bits = '0;
    for (int r = 0; r < 9; r++) begin
      dclk = 1;
      if (r == 0) tx_en = 1;
      if (r == 4) fsync = 0;
      half();
      if (r < 8) bits[7-r] = tx_dat;
      if (r == 0) chk("R2 tx_oe high in window", 32'(tx_oe), 32'd1);
      dclk = 0;
      if (mid_fs && r == 3) fsync = 1;
      half();
    end
    tx_en = 0; half(); half();
    chk("R2 tx_oe low outside window", 32'(tx_oe), 32'd0);
  endtask

  logic [7:0] bv = '0, last_rx = '0, exp_tx = '0, bits, rw, nv;
  logic [1:0] bs = '0, ns;
  logic       bvld = 0, nvl;

  initial begin
    void'($urandom(32'd4242));
    repeat (10) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 tx_oe", 32'(tx_oe), 0);
    chk("R8 stat_oe", 32'(stat_oe), 0);
    chk("R8 mod_voice", 32'(mod_voice), 0);
    chk("R8 status", {29'd0, so1, so2, vd}, 0);
    chk("R8 pd_q/lb_q", {30'd0, pd_q, lb_q}, 0);
    sen = 1; half();

    for (int k = 0; k < 14; k++) begin
      ins = (k < 2) ? k[0] : 1'($urandom % 2);
      si1 = 1'($urandom % 2); si2 = 1'($urandom % 2);
      half(); half();
      rw = (k == 2) ? 8'h01 : (k == 3) ? 8'hFE : 8'($urandom);
      rx_word(rw);
      last_rx = rw;
      if ($urandom % 4 != 0) begin
        nv = 8'($urandom); ns = 2'($urandom); nvl = 1'($urandom % 2) | k[0];
        strobe(nv, ns, nvl);
        bv = nv; bs = ns; bvld = nvl;
      end
      fs_pulse();
      chk(ins ? "R5 mod_voice lsb cleared" : "R1 mod_voice word", 32'(mod_voice), 32'(f_mv(rw, ins)));
      chk(ins ? "R5 mod_sig from rx lsb" : "R4 mod_sig", 32'(mod_sig), 32'(f_ms(si1, si2, rw, ins)));
      chk("R4 so1/so2", {30'd0, so1, so2}, {30'd0, bs[0], bs[1]});
      chk("R7 vd from buffered frame", 32'(vd), 32'(bvld));
      exp_tx = f_tx(bv, bs[1], ins);
      bvld = 0;
      tx_window(1'b0, bits);
      chk(ins ? "R5 tx lsb carries sig2" : "R2 tx word", 32'(bits), 32'(exp_tx));
    end

    // R3 deferred reload when frame sync lands inside the window
    strobe(8'hC3, 2'b10, 1'b1);
    bv = 8'hC3; bs = 2'b10;
    tx_window(1'b1, bits);
    chk("R3 word in progress kept", 32'(bits), 32'(exp_tx));
    chk("R7 vd after mid-window sync", 32'(vd), 32'd1);
    chk("R1 mod_voice at mid-window sync", 32'(mod_voice), 32'(f_mv(last_rx, ins)));
    exp_tx = f_tx(bv, bs[1], ins);
    tx_window(1'b0, bits);
    chk("R3 deferred word sent next", 32'(bits), 32'(exp_tx));
    fs_pulse();
    chk("R7 vd low without strobe", 32'(vd), 32'd0);

    // R6 bus-sharing hold, R9 pass-through
    ins = 0; si1 = 1; si2 = 0; pd = 1; lb = 1;
    half(); half();
    chk("R9 pd_q follows", 32'(pd_q), 1);
    chk("R9 lb_q follows", 32'(lb_q), 1);
    chk("R6 stat_oe high when enabled", 32'(stat_oe), 1);
    sen = 0; half(); half();
    ins = 1; si1 = 0; si2 = 1; pd = 0; lb = 0;
    half(); half();
    chk("R6 stat_oe low", 32'(stat_oe), 0);
    chk("R6 pd_q held", 32'(pd_q), 1);
    chk("R6 lb_q held", 32'(lb_q), 1);
    rx_word(8'hA5);
    fs_pulse();
    chk("R6 mod_sig uses held inputs", 32'(mod_sig), 32'(2'b01));
    chk("R6 insert mode held off", 32'(mod_voice), 32'h A5);
    sen = 1; half(); half();
    chk("R9 pd_q updates after enable", 32'(pd_q), 0);
    chk("R6 stat_oe restored", 32'(stat_oe), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule